// File: doc/BRIEF.md
# SHA-2 Message Padding Unit

This block sits in front of a SHA-2 compression core and turns a raw message, delivered one byte per handshake, into the sequence of complete blocks the core expects. It stores bytes into a block-sized buffer. When the message ends it places the marker byte and relies on the cleared buffer for the zero fill. It then writes the message length in bits into the tail of the block. When the marker leaves too little room for the length field, it releases the current block and builds one more block that holds only zeros and the length.

A single parameter picks the family. In the narrow setting blocks are 64 bytes with an 8-byte length field. In the wide setting blocks are 128 bytes with a 16-byte length field, and the upper half of that field is always zero. A whole block is offered at once on a flat vector. Message byte 0 sits in the top byte lane, so the vector reads as a run of big-endian 32-bit words in the narrow setting or 64-bit words in the wide setting. A flag marks the block that closes the message.

Top module: `sha2_msg_pad`

## Requirements
- R1: The byte 0x80 is placed in the buffer position directly after the final message byte.
- R2: When the final message byte fills a block, that block is released unchanged and the next block carries 0x80 in byte position 0.
- R3: Every byte between the marker and the length field is zero. The length field occupies the last 8 byte positions (narrow setting) or the last 16 (wide setting, with its first 8 bytes zero).
- R4: If fewer bytes than the length field needs remain after the marker, the current block is released with its final flag low. A further block of zeros ending in the length field follows with the final flag high.
- R5: The length field holds the message byte count times eight, most significant byte first, least significant byte in the last position of the block.
- R6: Byte position 0 of a block appears on the top 8 bits of `outBlock`, and each later position sits 8 bits lower.
- R7: A beat with both `inLast` and `inNoData` high and no earlier bytes yields one block: 0x80 in position 0, then zeros, then a length of zero.
- R8: `inReady` is low whenever `outValid` is high or the marker and length are being placed. `inReady` is high after reset. The byte count returns to zero once the final block is accepted, so the next message's length starts from zero.
- R9: While `outValid` is high and `outReady` is low, `outBlock` and `outFinal` keep their values.
- R10: Message blocks released before the end of the message carry the message bytes in order, with the final flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Unit can take an input beat |
| inData | input | 8 | Message byte |
| inLast | input | 1 | Beat ends the message |
| inNoData | input | 1 | Beat carries no byte (used with inLast for an empty message) |
| outValid | output | 1 | A complete block is offered |
| outReady | input | 1 | Consumer takes the block |
| outBlock | output | 512 or 1024 | Block contents, byte 0 in the top lane |
| outFinal | output | 1 | Offered block closes the message |

## Verification
Properties checked every cycle cover the output hold under back-pressure, input stalling while a block is offered, and the guards that the marker never lands in a full block and the length is written only where it fits. The bench supplies the rest. It checks the exact placement of marker, zero fill and length across the lengths where the fit decision flips (55, 56, 63 and 64 bytes in the narrow setting). It also checks the extra-block count, the empty message, and the counter restart between back-to-back messages.

// File: rtl/sha2_pad_pkg.sv
package sha2_pad_pkg;

  // Strobes from the sequencer to the buffer datapath
  typedef struct packed {
    logic loadByte;    // store inData at the fill position
    logic putMarker;   // store 0x80 at the fill position
    logic putLength;   // write the bit count into the block tail
    logic clearBlock;  // zero the buffer and rewind the position
    logic clearCount;  // restart the message byte count
  } padCtrl_t;

  typedef enum logic [1:0] {
    ST_FILL,
    ST_MARK,
    ST_LENGTH,
    ST_SEND
  } padState_t;

endpackage

// File: rtl/sha2_pad_datapath.sv
module sha2_pad_datapath
  import sha2_pad_pkg::*;
#(
  parameter int BLOCK_BYTES = 64,
  parameter int LEN_BYTES   = 8,
  parameter int CNT_W       = 61
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  padCtrl_t                 ctrl,
  input  logic [7:0]               inData,
  output logic [BLOCK_BYTES*8-1:0] blockOut,
  output logic                     blockFull,
  output logic                     lastSlot,
  output logic                     lenFits
);

  localparam int POS_W    = $clog2(BLOCK_BYTES) + 1;
  localparam int BLOCK_W  = BLOCK_BYTES * 8;
  localparam int FIT_EDGE = BLOCK_BYTES - LEN_BYTES;

  logic [POS_W-1:0]   pos;
  logic [CNT_W-1:0]   byteCount;
  logic [63:0]        bitLen;
  logic [BLOCK_W-1:0] blockReg;
  logic [BLOCK_W-1:0] blockNext;

  assign bitLen = 64'(byteCount) << 3;

  always_comb begin
    blockNext = blockReg;
    if (ctrl.clearBlock) begin
      blockNext = '0;
    end else begin
      for (int i = 0; i < BLOCK_BYTES; i++) begin
        if ((ctrl.loadByte || ctrl.putMarker) && pos == POS_W'(i)) begin
          blockNext[(BLOCK_BYTES-1-i)*8 +: 8] = ctrl.loadByte ? inData : 8'h80;
        end
      end
      if (ctrl.putLength) begin
        blockNext[63:0] = bitLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockReg  <= '0;
      pos       <= '0;
      byteCount <= '0;
    end else begin
      blockReg <= blockNext;
      if (ctrl.clearBlock) begin
        pos <= '0;
      end else if (ctrl.loadByte || ctrl.putMarker) begin
        pos <= pos + 1'b1;
      end
      if (ctrl.clearCount) begin
        byteCount <= '0;
      end else if (ctrl.loadByte) begin
        byteCount <= byteCount + 1'b1;
      end
    end
  end

  assign blockOut  = blockReg;
  assign blockFull = (pos == POS_W'(BLOCK_BYTES));
  assign lastSlot  = (pos == POS_W'(BLOCK_BYTES - 1));
  assign lenFits   = (pos <= POS_W'(FIT_EDGE));

  // R2
  marker_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.putMarker |-> pos < POS_W'(BLOCK_BYTES));

  // R4
  length_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.putLength |-> pos <= POS_W'(FIT_EDGE));

  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pos <= POS_W'(BLOCK_BYTES));

endmodule

// File: rtl/sha2_pad_ctrl.sv
module sha2_pad_ctrl
  import sha2_pad_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     inNoData,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output logic     outFinal,
  input  logic     blockFull,
  input  logic     lastSlot,
  input  logic     lenFits,
  output padCtrl_t ctrl
);

  padState_t state, stateNext;
  padState_t retState, retNext;
  logic      finalFlag, finalNext;

  always_comb begin
    ctrl      = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    stateNext = state;
    retNext   = retState;
    finalNext = finalFlag;
    unique case (state)
      ST_FILL: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.loadByte = !inNoData;
          if (inLast) begin
            stateNext = ST_MARK;
          end else if (!inNoData && lastSlot) begin
            stateNext = ST_SEND;
            retNext   = ST_FILL;
            finalNext = 1'b0;
          end
        end
      end
      ST_MARK: begin
        if (blockFull) begin
          stateNext = ST_SEND;
          retNext   = ST_MARK;
          finalNext = 1'b0;
        end else begin
          ctrl.putMarker = 1'b1;
          stateNext      = ST_LENGTH;
        end
      end
      ST_LENGTH: begin
        stateNext = ST_SEND;
        if (lenFits) begin
          ctrl.putLength = 1'b1;
          retNext        = ST_FILL;
          finalNext      = 1'b1;
        end else begin
          retNext   = ST_LENGTH;
          finalNext = 1'b0;
        end
      end
      ST_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          ctrl.clearBlock = 1'b1;
          ctrl.clearCount = finalFlag;
          stateNext       = retState;
        end
      end
      default: stateNext = ST_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_FILL;
      retState  <= ST_FILL;
      finalFlag <= 1'b0;
    end else begin
      state     <= stateNext;
      retState  <= retNext;
      finalFlag <= finalNext;
    end
  end

  assign outFinal = (state == ST_SEND) && finalFlag;

  // R9
  final_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outFinal));

  // R8
  in_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

endmodule

// File: rtl/sha2_msg_pad.sv
module sha2_msg_pad
  import sha2_pad_pkg::*;
#(
  parameter bit WIDE_MODE = 1'b0,
  parameter int CNT_W     = 61,
  localparam int BLOCK_BYTES = WIDE_MODE ? 128 : 64,
  localparam int LEN_BYTES   = WIDE_MODE ? 16 : 8,
  localparam int BLOCK_W     = BLOCK_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [7:0]         inData,
  input  logic               inLast,
  input  logic               inNoData,
  output logic               outValid,
  input  logic               outReady,
  output logic [BLOCK_W-1:0] outBlock,
  output logic               outFinal
);

  padCtrl_t ctrl;
  logic     blockFull;
  logic     lastSlot;
  logic     lenFits;

  sha2_pad_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .inNoData (inNoData),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .outFinal (outFinal),
    .blockFull(blockFull),
    .lastSlot (lastSlot),
    .lenFits  (lenFits),
    .ctrl     (ctrl)
  );

  sha2_pad_datapath #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .LEN_BYTES  (LEN_BYTES),
    .CNT_W      (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inData   (inData),
    .blockOut (outBlock),
    .blockFull(blockFull),
    .lastSlot (lastSlot),
    .lenFits  (lenFits)
  );

  // R9
  block_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outBlock));

endmodule

// File: tb/sha2_msg_pad_bench.sv
module sha2_msg_pad_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BLK   = 64;
  localparam int LENB  = 8;
  localparam int BW    = BLK * 8;
  localparam int NUM   = 9;
  localparam int msgLen [NUM] = '{0, 3, 55, 56, 63, 64, 100, 119, 120};
  localparam int expBlk [NUM] = '{1, 1, 1, 2, 2, 2, 2, 2, 3};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [7:0]    inData = '0;
  logic          inLast = 1'b0;
  logic          inNoData = 1'b0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [BW-1:0] outBlock;
  logic          outFinal;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha2_msg_pad #(.WIDE_MODE(1'b0)) u_sha2_msg_pad (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .inNoData(inNoData),
    .outValid(outValid), .outReady(outReady),
    .outBlock(outBlock), .outFinal(outFinal)
  );

  function automatic logic [7:0] msgByte(input int len, input int k);
    return 8'((k * 7) + (len * 13) + 1);
  endfunction

  function automatic logic [7:0] expByte(input int len, input int j, input int total);
    logic [63:0] bits;
    bits = 64'(len) * 64'd8;
    if (j < len) return msgByte(len, j);
    if (j == len) return 8'h80;
    if (j >= total - 8) return 8'(bits >> (8 * (total - 1 - j)));
    return 8'h00;
  endfunction

  task automatic runMsg(input int len, input int nBlk, input bit stall,
                        output logic [BW-1:0] firstSeen);
    int total;
    int sent = 0;
    int blk = 0;
    int cyc = 0;
    bit done = 0;
    bit lastSent = 0;
    bit holding = 0;
    logic [BW-1:0] held;
    logic [BW-1:0] expv;
    total = ((len + 1 + LENB + BLK - 1) / BLK) * BLK;
    firstSeen = '0;
    held = '0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      inValid = 0; inLast = 0; inNoData = 0; outReady = 0;
      if (outValid) begin
        checks++;
        if (inReady) begin
          errors++;
          $display("FAIL R8 inReady high during output: actual %0b expected 0", inReady);
        end
        if (stall && !holding) begin
          held = outBlock;
          holding = 1;
        end else begin
          if (holding) begin
            checks++;
            if (outBlock !== held) begin
              errors++;
              $display("FAIL R9 block changed under stall: actual %h expected %h", outBlock, held);
            end
            holding = 0;
          end
          for (int j = 0; j < BLK; j++)
            expv[(BLK-1-j)*8 +: 8] = expByte(len, blk * BLK + j, total);
          checks++;
          // R1 R2 R3 R5 R7 R10 contents
          if (outBlock !== expv) begin
            errors++;
            $display("FAIL R1 R3 R5 R7 R10 len %0d block %0d: actual %h expected %h",
                     len, blk, outBlock, expv);
          end
          if (blk == 0) firstSeen = outBlock;
          checks++;
          if (outFinal !== (blk == nBlk - 1)) begin
            errors++;
            $display("FAIL R4 final flag len %0d block %0d: actual %0b expected %0b",
                     len, blk, outFinal, (blk == nBlk - 1));
          end
          outReady = 1;
          if (outFinal) done = 1;
          blk++;
        end
      end else if (inReady && !lastSent) begin
        inValid = 1;
        if (len == 0) begin
          inNoData = 1; inLast = 1; lastSent = 1;
        end else begin
          inData = msgByte(len, sent);
          inLast = (sent == len - 1);
          if (sent == len - 1) lastSent = 1;
          sent++;
        end
      end
    end
    checks++;
    // R2 R4 block count
    if (blk != nBlk) begin
      errors++;
      $display("FAIL R2 R4 block count len %0d: actual %0d expected %0d", len, blk, nBlk);
    end
  endtask

  initial begin
    logic [BW-1:0] first;
    logic [BW-1:0] firstShort;
    firstShort = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    // R8 reset state
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset state: actual valid %0b ready %0b expected valid 0 ready 1",
               outValid, inReady);
    end
    // Table walk; messages run back to back so each length also shows the
    // count restart of R8
    for (int v = 0; v < NUM; v++) begin
      runMsg(msgLen[v], expBlk[v], v[0], first);
      if (msgLen[v] == 3) firstShort = first;
    end
    @(negedge clk);
    outReady = 0;
    checks++;
    // R6 lane order on the first 32-bit word of the 3-byte message
    if (firstShort[BW-1 -: 32] !== {msgByte(3, 0), msgByte(3, 1), msgByte(3, 2), 8'h80}) begin
      errors++;
      $display("FAIL R6 first word: actual %h expected %h", firstShort[BW-1 -: 32],
               {msgByte(3, 0), msgByte(3, 1), msgByte(3, 2), 8'h80});
    end
    // Directed: repeat the 64-byte case with stall to hit R2 under back-pressure
    runMsg(64, 2, 1'b1, first);
    // Directed: empty message again after a long one, R7 and R8
    runMsg(0, 1, 1'b0, first);
    @(negedge clk);
    outReady = 0;
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      errors++;
      $display("FAIL R8 idle after final: actual valid %0b ready %0b expected valid 0 ready 1",
               outValid, inReady);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule